// File: doc/BRIEF.md
# CAN Bit Timer and Phase Synchronizer

This block produces the bit timing of a CAN receiver. It runs on a single time-quantum enable. Each bit is split into four parts that always come in the same order: one synchronization quantum, a propagation part, a first phase buffer and a second phase buffer. The receive line is sampled where the first phase buffer ends. The block puts out a one-clock strobe together with the sampled level, and a second one-clock strobe when each bit begins.

The block follows the phase of the transmitter. It watches for recessive-to-dominant transitions on the synchronized receive line. While the hard-sync enable is high, such an edge restarts the bit at once. While it is low, the block measures how far the edge is from where it was expected. It then lengthens the first phase buffer for a late edge, or cuts the second phase buffer short for an early edge. Each correction is limited to the programmed jump width. After a sample point, only the first edge is acted on until the next sample point.

Frame decoding, arbitration and acknowledge handling belong to other blocks. They drive the hard-sync enable and consume the sample strobe and the sampled bit.

Top module: `can_bit_timer`

## Requirements
- R1: While and right after reset, with no quantum tick yet, `sample_stb` and `bit_start` are 0 and `rx_bit` is 1 (recessive).
- R2: Let the bit have `1 + prop_len + ph1_len + ph2_len` quanta, numbered from 0 at reset. With no edges, `bit_start` pulses for the tick that ends quantum 0 of each bit. `sample_stb` pulses for the tick that ends quantum `prop_len + ph1_len` of each bit. Each pulse is one clock wide, in the clock right after the tick.
- R3: `rx_bit` takes the synchronized receive level at the sample tick and changes only in the clock where `sample_stb` is 1. `rx_in` passes through a two-flop synchronizer, so it must be stable for two clocks before a tick.
- R4: A receive level that stays dominant (0) across sample points causes no adjustment, so consecutive samples stay one nominal bit apart.
- R5: An edge is a dominant level at a tick while the last sampled bit is recessive. When such an edge is seen with `hard_en` = 1, the quantum of the edge becomes the synchronization quantum of a new bit, wherever the bit was. `bit_start` pulses for that tick and the next sample comes `prop_len + ph1_len` ticks later.
- R6: With `hard_en` = 0, an edge in the synchronization quantum has zero phase error and leaves the timing unchanged.
- R7: With `hard_en` = 0, an edge in the propagation part or the first phase buffer has a phase error equal to its quantum index in the bit. That buffer is lengthened by the smaller of the error and `sjw`, which delays the sample and the next bit by that amount.
- R8: With `hard_en` = 0, an edge in the second phase buffer at offset c has error `ph2_len - c`. That buffer is shortened by the smaller of the error and `sjw`. If the error is at most `sjw`, the synchronization quantum is skipped and the next bit starts at once, as with a hard sync. Otherwise one sync quantum still follows, leaving a residual of error minus `sjw`.
- R9: After the first synchronization (hard or resync) following a sample point, further edges are ignored until the next sample point.
- R10: Two consecutive sample strobes are at least `prop_len + ph1_len + 1` ticks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tq_tick | input | 1 | One-clock enable marking the end of each time quantum |
| prop_len | input | LEN_W | Propagation part length in quanta, 1 to 8 |
| ph1_len | input | LEN_W | First phase buffer length, 1 to 8 |
| ph2_len | input | LEN_W | Second phase buffer length, 2 to 8 |
| sjw | input | SJW_W | Jump width, 1 to 4, not above either phase buffer |
| hard_en | input | 1 | Selects restart of the bit on the next edge instead of a limited correction |
| rx_in | input | 1 | Asynchronous receive line, 1 recessive, 0 dominant |
| sample_stb | output | 1 | One-clock pulse at each sample point |
| rx_bit | output | 1 | Level taken at the latest sample point |
| bit_start | output | 1 | One-clock pulse when a bit's synchronization quantum ends |

## Verification
The bench builds the block with its default widths, `LEN_W` = 4 and `SJW_W` = 3. It then sweeps a short configuration space: propagation 1 to 2, first buffer 1 to 3, second buffer 2 to 3, every legal jump width. In each configuration it places a single edge in every quantum position of a bit, once under hard sync and once under resync. Short bits make the full set of late, early, clipped and unclipped cases cheap to cover. The residual after clipping shows up whenever the position is farther than the jump width. A second pass adds a spike right after the first edge to exercise the one-correction rule. A final pass uses the largest lengths and jump width, which drives the counters and sums to their widest values.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PROP = 2'd1,
    SEG_PH1  = 2'd2,
    SEG_PH2  = 2'd3
  } seg_e;
endpackage

// File: rtl/cbt_rx_sync.sv
module cbt_rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= RST_VAL;
        else     chain_q <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RST_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/cbt_phase_err.sv
// Phase error of an edge seen in the current quantum, and its clipped form.
module cbt_phase_err
  import cbt_pkg::*;
#(
  parameter int LEN_W = 4,
  parameter int SJW_W = 3
) (
  input  seg_e             seg,
  input  logic [LEN_W:0]   cnt,
  input  logic [LEN_W-1:0] prop_len,
  input  logic [LEN_W-1:0] ph2_len,
  input  logic [SJW_W-1:0] sjw,
  output logic [SJW_W-1:0] late_clip,
  output logic             early_full
);
  localparam int SW = LEN_W + 2;

  logic [SW-1:0] cnt_x, late_err, early_err, sjw_x;

  always_comb begin
    cnt_x = SW'(cnt);
    sjw_x = SW'(sjw);
    // quantum index within the bit: sync is 0, first prop quantum is 1
    if (seg == SEG_PROP) late_err = cnt_x + SW'(1);
    else                 late_err = SW'(prop_len) + cnt_x + SW'(1);
    // quanta left in the second buffer, the current one included
    early_err  = SW'(ph2_len) - cnt_x;
    late_clip  = (late_err > sjw_x) ? sjw : SJW_W'(late_err);
    early_full = (early_err <= sjw_x);
  end
endmodule

// File: rtl/cbt_seg_ctrl.sv
// Segment sequencer with hard sync and limited resynchronization.
module cbt_seg_ctrl
  import cbt_pkg::*;
#(
  parameter int LEN_W = 4,
  parameter int SJW_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tq_tick,
  input  logic             hard_en,
  input  logic             rx_s,
  input  logic [LEN_W-1:0] prop_len,
  input  logic [LEN_W-1:0] ph1_len,
  input  logic [LEN_W-1:0] ph2_len,
  input  logic [SJW_W-1:0] sjw,
  input  logic [SJW_W-1:0] late_clip,
  input  logic             early_full,
  output seg_e             seg,
  output logic [LEN_W:0]   cnt,
  output logic             sample_stb,
  output logic             rx_bit,
  output logic             bit_start
);
  localparam int CNT_W = LEN_W + 1;
  localparam int SW    = LEN_W + 2;

  seg_e             seg_q, seg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SJW_W-1:0] ext_q, ext_d, eff_ext;
  logic [SJW_W-1:0] cut_q, cut_d, eff_cut;
  logic             done_q, done_d;
  logic             rxb_q, samp_d, bst_d, samp_q, bst_q;
  logic             edge_ok, jump;
  logic [SW-1:0]    cnt_x, prop_end, ph1_end, ph2_end;

  always_comb begin
    edge_ok  = rxb_q && !rx_s && !done_q;
    seg_d    = seg_q;
    cnt_d    = cnt_q;
    ext_d    = ext_q;
    cut_d    = cut_q;
    done_d   = done_q;
    samp_d   = 1'b0;
    bst_d    = 1'b0;
    eff_ext  = ext_q;
    eff_cut  = cut_q;
    jump     = 1'b0;
    cnt_x    = SW'(cnt_q);
    prop_end = SW'(prop_len) - SW'(1);
    ph1_end  = '0;
    ph2_end  = '0;

    if (tq_tick) begin
      if (edge_ok && hard_en) begin
        // edge quantum becomes the sync quantum of a new bit
        seg_d  = SEG_PROP;
        cnt_d  = '0;
        ext_d  = '0;
        cut_d  = '0;
        done_d = 1'b1;
        bst_d  = 1'b1;
      end else begin
        if (edge_ok) begin
          done_d = 1'b1;
          case (seg_q)
            SEG_PROP, SEG_PH1: eff_ext = late_clip;
            SEG_PH2: begin
              if (early_full) jump = 1'b1;
              else            eff_cut = sjw;
            end
            default: ;
          endcase
        end
        ph1_end = SW'(ph1_len) + SW'(eff_ext) - SW'(1);
        ph2_end = SW'(ph2_len) - SW'(eff_cut) - SW'(1);
        ext_d   = eff_ext;
        cut_d   = eff_cut;

        if (jump) begin
          seg_d = SEG_PROP;
          cnt_d = '0;
          cut_d = '0;
          bst_d = 1'b1;
        end else begin
          case (seg_q)
            SEG_SYNC: begin
              seg_d = SEG_PROP;
              cnt_d = '0;
              bst_d = 1'b1;
            end
            SEG_PROP: begin
              if (cnt_x == prop_end) begin
                seg_d = SEG_PH1;
                cnt_d = '0;
              end else begin
                cnt_d = cnt_q + CNT_W'(1);
              end
            end
            SEG_PH1: begin
              if (cnt_x == ph1_end) begin
                seg_d  = SEG_PH2;
                cnt_d  = '0;
                ext_d  = '0;
                done_d = 1'b0;
                samp_d = 1'b1;
              end else begin
                cnt_d = cnt_q + CNT_W'(1);
              end
            end
            default: begin
              if (cnt_x == ph2_end) begin
                seg_d = SEG_SYNC;
                cnt_d = '0;
                cut_d = '0;
              end else begin
                cnt_d = cnt_q + CNT_W'(1);
              end
            end
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q  <= SEG_SYNC;
      cnt_q  <= '0;
      ext_q  <= '0;
      cut_q  <= '0;
      done_q <= 1'b0;
      rxb_q  <= 1'b1;
      samp_q <= 1'b0;
      bst_q  <= 1'b0;
    end else begin
      seg_q  <= seg_d;
      cnt_q  <= cnt_d;
      ext_q  <= ext_d;
      cut_q  <= cut_d;
      done_q <= done_d;
      samp_q <= samp_d;
      bst_q  <= bst_d;
      if (samp_d) rxb_q <= rx_s;
    end
  end

  assign seg        = seg_q;
  assign cnt        = cnt_q;
  assign sample_stb = samp_q;
  assign bit_start  = bst_q;
  assign rx_bit     = rxb_q;
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import cbt_pkg::*;
#(
  parameter int LEN_W       = 4,
  parameter int SJW_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tq_tick,
  input  logic [LEN_W-1:0] prop_len,
  input  logic [LEN_W-1:0] ph1_len,
  input  logic [LEN_W-1:0] ph2_len,
  input  logic [SJW_W-1:0] sjw,
  input  logic             hard_en,
  input  logic             rx_in,
  output logic             sample_stb,
  output logic             rx_bit,
  output logic             bit_start
);
  logic             rx_s;
  seg_e             seg;
  logic [LEN_W:0]   cnt;
  logic [SJW_W-1:0] late_clip;
  logic             early_full;

  cbt_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rx_in),
    .dout (rx_s)
  );

  cbt_phase_err #(.LEN_W(LEN_W), .SJW_W(SJW_W)) u_perr (
    .seg        (seg),
    .cnt        (cnt),
    .prop_len   (prop_len),
    .ph2_len    (ph2_len),
    .sjw        (sjw),
    .late_clip  (late_clip),
    .early_full (early_full)
  );

  cbt_seg_ctrl #(.LEN_W(LEN_W), .SJW_W(SJW_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .tq_tick    (tq_tick),
    .hard_en    (hard_en),
    .rx_s       (rx_s),
    .prop_len   (prop_len),
    .ph1_len    (ph1_len),
    .ph2_len    (ph2_len),
    .sjw        (sjw),
    .late_clip  (late_clip),
    .early_full (early_full),
    .seg        (seg),
    .cnt        (cnt),
    .sample_stb (sample_stb),
    .rx_bit     (rx_bit),
    .bit_start  (bit_start)
  );
endmodule

// File: rtl/cbt_chk.sv
module cbt_chk #(
  parameter int LEN_W = 4,
  parameter int SJW_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             tq_tick,
  input logic [LEN_W-1:0] prop_len,
  input logic [LEN_W-1:0] ph1_len,
  input logic [SJW_W-1:0] sjw,
  input logic             sample_stb,
  input logic             rx_bit,
  input logic             bit_start
);
  logic [7:0] gap_q;
  logic       seen_q;
  logic [7:0] min_gap;

  assign min_gap = 8'(prop_len) + 8'(ph1_len) + 8'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (sample_stb) begin
      gap_q  <= tq_tick ? 8'd1 : 8'd0;
      seen_q <= 1'b1;
    end else if (tq_tick && gap_q != 8'hFF) begin
      gap_q <= gap_q + 8'd1;
    end
  end

  // R2
  sample_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> $past(tq_tick));

  // R2
  start_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    bit_start |-> $past(tq_tick));

  // R2
  no_strobe_clash_chk: assert property (@(posedge clk) disable iff (rst)
    !(sample_stb && bit_start));

  // R3
  bit_held_chk: assert property (@(posedge clk) disable iff (rst)
    !sample_stb |-> $stable(rx_bit));

  // R10
  min_sample_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_stb && seen_q) |-> (gap_q >= min_gap));

  // unused width bits of sjw kept for a uniform port set
  logic unused_ok;
  assign unused_ok = ^sjw;
endmodule

bind can_bit_timer cbt_chk #(.LEN_W(LEN_W), .SJW_W(SJW_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tq_tick    (tq_tick),
  .prop_len   (prop_len),
  .ph1_len    (ph1_len),
  .sjw        (sjw),
  .sample_stb (sample_stb),
  .rx_bit     (rx_bit),
  .bit_start  (bit_start)
);

// File: tb/can_bit_timer_tb.sv
module can_bit_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TQ_DIV     = 4;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tq_tick = 1'b0;
  logic       hard_en = 1'b0;
  logic       rx_in = 1'b1;
  logic [3:0] prop_len = 4'd1;
  logic [3:0] ph1_len = 4'd1;
  logic [3:0] ph2_len = 4'd2;
  logic [2:0] sjw = 3'd1;
  logic       sample_stb, rx_bit, bit_start;

  int n_chk  = 0;
  int n_fail = 0;

  can_bit_timer u_dut (
    .clk(clk), .rst(rst), .tq_tick(tq_tick), .prop_len(prop_len),
    .ph1_len(ph1_len), .ph2_len(ph2_len), .sjw(sjw), .hard_en(hard_en),
    .rx_in(rx_in), .sample_stb(sample_stb), .rx_bit(rx_bit), .bit_start(bit_start)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tq_tick = 1'b0; rx_in = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(int'(sample_stb), 0, "R1 sample_stb after reset");
    check(int'(bit_start), 0, "R1 bit_start after reset");
    check(int'(rx_bit), 1, "R1 rx_bit after reset");
  endtask

  task automatic quantum(input logic rv, output logic s, output logic b, output logic v);
    rx_in = rv;
    tq_tick = 1'b0;
    repeat (TQ_DIV-1) @(negedge clk);
    tq_tick = 1'b1;
    @(negedge clk);
    tq_tick = 1'b0;
    s = sample_stb; b = bit_start; v = rx_bit;
  endtask

  task automatic run_case(input int p, input int a, input int b2, input int j,
                          input bit hard, input int pos, input bit glitch);
    int L, q, e, d, exp_s, exp_b, s0, v0, sa1, sa2, va1, bs1;
    string tag;
    logic s, b, v, rv;
    prop_len = 4'(p); ph1_len = 4'(a); ph2_len = 4'(b2); sjw = 3'(j);
    hard_en = hard;
    do_reset();
    L = 1 + p + a + b2;
    q = 2 * L + pos;
    if (hard) begin
      exp_s = q + p + a; exp_b = q; tag = "R5 hard sync";
    end else if (pos == 0) begin
      exp_s = q + p + a; exp_b = q; tag = "R6 sync-quantum edge";
    end else if (pos <= p + a) begin
      exp_s = q - pos + p + a + imin(pos, j);
      exp_b = q - pos + L + imin(pos, j);
      tag = "R7 late edge";
    end else begin
      e = L - pos;
      d = e - imin(e, j);
      exp_s = q + d + p + a; exp_b = q + d; tag = "R8 early edge";
    end
    if (glitch) tag = {tag, " R9 second edge ignored"};
    s0 = -1; v0 = -1; sa1 = -1; sa2 = -1; va1 = -1; bs1 = -1;
    for (int qi = 0; qi < q + 3 * L + 5; qi++) begin
      if (qi < q) rv = 1'b1;
      else if (glitch && qi == q + 1) rv = 1'b1;
      else rv = 1'b0;
      quantum(rv, s, b, v);
      if (s && s0 < 0) begin s0 = qi; v0 = int'(v); end
      if (qi >= q) begin
        if (s && sa1 >= 0 && sa2 < 0) sa2 = qi;
        if (s && sa1 < 0) begin sa1 = qi; va1 = int'(v); end
        if (b && bs1 < 0) bs1 = qi;
      end
    end
    check(s0, p + a, "R2 first nominal sample point");
    check(v0, 1, "R3 idle sampled level");
    check(sa1, exp_s, {tag, " sample point"});
    check(bs1, exp_b, {tag, " bit start"});
    check(va1, 0, "R3 sampled dominant after edge");
    check(sa2 - sa1, L, "R4 steady dominant keeps nominal bit (R10)");
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int p = 1; p <= 2; p++)
      for (int a = 1; a <= 3; a++)
        for (int b2 = 2; b2 <= 3; b2++)
          for (int j = 1; j <= imin(a, b2); j++) begin
            for (int hd = 0; hd < 2; hd++)
              for (int pos = 0; pos < 1 + p + a + b2; pos++)
                run_case(p, a, b2, j, bit'(hd), pos, 1'b0);
            run_case(p, a, b2, j, 1'b0, 1, 1'b1);
            run_case(p, a, b2, j, 1'b1, 1, 1'b1);
          end
    for (int pos = 0; pos < 25; pos++)
      run_case(8, 8, 8, 4, 1'b0, pos, 1'b0);
    run_case(8, 8, 8, 4, 1'b1, 20, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule